// File: doc/BRIEF.md
# Slot Interrupt Aggregation Controller

This block gathers the four PCI interrupt lines (A to D) from up to four primary slots into one interrupt request and a vector number. A primary slot may hold one device, which uses only its four lines, or a bridge. Behind a bridge sit four secondary slots, and each of them brings its own four lines. Software reaches the block through 16-bit register accesses on a simple address/write-enable/data bus, and reads come back combinationally.

A configuration register at a fixed address reports which primary slots hold bridges. The same register holds a relocatable base address for a window of eight registers. Each slot owns a status and mask pair inside that window. A master register at a fixed address shows one pending bit per slot and holds the slot-level masks and the global controls. The request output fires when the global enable is set and an unmasked source is pending. The vector output names the lowest-numbered pending source.

Top module: `slot_irq_agg`

## Requirements
- R1: After reset the base field is 0x051 (window at 0x510), every mask bit, the global enable, the mask-enable, the owner bit and the mode bit are 0, `irq_out` is 0 and `irq_vec` is 0.
- R2: The configuration register at 0x502 reads `{base[11:0], bridge_cfg[3:0]}`, where bit 0 of `bridge_cfg` is slot 1. Writes load `base` from bits 15:4 and have no effect on bits 3:0. Status of slot n sits at address `{base,4'h0} + 4(n-1)` and its mask sits 2 bytes above that.
- R3: Line `irq_lines[16(n-1)+i]` feeds bit i of the status register of slot n. It passes through two synchroniser flops, so a change shows up after the second rising edge. When slot n is bridged, bits 4(k-1)+3..4(k-1) carry lines A..D of secondary slot k. When slot n is not bridged, bits 15:4 read 0 and the lines feeding them have no effect.
- R4: Writes to a status register change neither its value nor any mask.
- R5: Mask registers can be written and read back, and bits 15:4 read 0 for a slot that is not bridged. When master bit 13 (mask-enable) is 1, a set mask bit removes the matching status bit from aggregation. When bit 13 is 0, the mask registers have no effect. Status reads always return the raw value.
- R6: The master register at 0x500 reads as follows: bits 3:0 give one pending bit per slot (bit 0 = slot 1); bits 5:4 read 0; bits 15:6 read back the last value written. Slot n's pending bit is the OR of its aggregated status bits, forced to 0 by master mask bit 6+n-1.
- R7: `irq_out` is 1 exactly when master bit 14 (global enable) is 1 and any master pending bit is 1.
- R8: When `irq_out` is 1, `irq_vec` = 0x11 + 0x10(n-1) + b for the pending source with the lowest slot n, and the lowest bit b within that slot. When `irq_out` is 0, `irq_vec` is 0.
- R9: A read from an address outside the master register, the configuration register and the eight-register window returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bridge_cfg | input | 4 | Bridge-present flags, bit 0 = slot 1 |
| irq_lines | input | 64 | Raw interrupt lines, 16 per primary slot |
| bus_addr | input | 16 | Register byte address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Combinational read data |
| irq_out | output | 1 | Combined interrupt request |
| irq_vec | output | 8 | Vector of lowest pending source, 0 if none |

## Verification
A register write takes effect at the clock edge that samples it. Reads are combinational, so a read issued on the next falling edge already sees the new value. A change on the interrupt lines reaches the status registers, `irq_out` and `irq_vec` only after two rising edges. The bench therefore drives every input on a falling edge and waits two full cycles before it samples those outputs. One directed test also checks that the request is still low after a single edge. The table rows mix bridged and plain slots, master masks and the global enable, and the directed tests cover the per-slot masks, status writes and relocation of the window.

// File: rtl/slot_irq_agg.sv
`timescale 1ns/1ps
module slot_irq_agg #(
  parameter logic [15:0] MST_ADDR  = 16'h0500,
  parameter logic [15:0] CFG_ADDR  = 16'h0502,
  parameter logic [11:0] BASE_RST  = 12'h051,
  parameter int          VEC_FIRST = 17
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [3:0]  bridge_cfg,
  input  logic [63:0] irq_lines,
  input  logic [15:0] bus_addr,
  input  logic        bus_we,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  output logic        irq_out,
  output logic [7:0]  irq_vec
);
  localparam int NSLOT = 4;
  localparam int SW    = 16;
  localparam int NL    = NSLOT * SW;

  logic [NL-1:0]             sync1, sync2;
  logic [11:0]               base;
  logic [NSLOT-1:0]          mmask;
  logic [1:0]                mres;
  logic                      own, msken, gie, mode;
  logic [NSLOT-1:0][SW-1:0]  smask;
  logic [NSLOT-1:0][SW-1:0]  stat, keep, eff;
  logic [NSLOT-1:0]          mstat;
  logic [NL-1:0]             eff_flat;
  logic [7:0]                vec_raw;

  wire hit_mst  = bus_addr == MST_ADDR;
  wire hit_cfg  = bus_addr == CFG_ADDR;
  wire hit_win  = !hit_mst && !hit_cfg && bus_addr[15:4] == base && !bus_addr[0];
  wire [1:0] widx = bus_addr[3:2];
  wire wsel_mask  = bus_addr[1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
    end else begin
      sync1 <= irq_lines;
      sync2 <= sync1;
    end

  genvar n;
  for (n = 0; n < NSLOT; n++) begin : g_slot
    assign keep[n]  = bridge_cfg[n] ? {SW{1'b1}} : {{(SW-4){1'b0}}, 4'hF};
    assign stat[n]  = sync2[n*SW +: SW] & keep[n];
    assign eff[n]   = stat[n] & ~(msken ? smask[n] : '0) & {SW{~mmask[n]}};
    assign mstat[n] = |eff[n];
    assign eff_flat[n*SW +: SW] = eff[n];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      base  <= BASE_RST;
      mmask <= '0;
      mres  <= '0;
      own   <= 1'b0;
      msken <= 1'b0;
      gie   <= 1'b0;
      mode  <= 1'b0;
      smask <= '0;
    end else if (bus_we) begin
      if (hit_mst)
        {mode, gie, msken, own, mres, mmask} <= bus_wdata[15:6];
      else if (hit_cfg)
        base <= bus_wdata[15:4];
      else if (hit_win && wsel_mask)
        smask[widx] <= bus_wdata;
    end

  always_comb begin
    bus_rdata = '0;
    if (hit_mst)
      bus_rdata = {mode, gie, msken, own, mres, mmask, 2'b00, mstat};
    else if (hit_cfg)
      bus_rdata = {base, bridge_cfg};
    else if (hit_win)
      bus_rdata = wsel_mask ? (smask[widx] & keep[widx]) : stat[widx];
  end

  always_comb begin
    vec_raw = '0;
    for (int i = NL - 1; i >= 0; i--)
      if (eff_flat[i]) vec_raw = 8'(VEC_FIRST + i);
  end

  assign irq_out = gie & |mstat;
  assign irq_vec = irq_out ? vec_raw : 8'h00;

  wire [5:0] vidx = 6'(irq_vec - 8'(VEC_FIRST));

  assert_irq_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> gie);
  assert_vec_nonzero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_vec != 8'h00) == irq_out);
  assert_vec_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> eff_flat[vidx]);
  assert_base_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && hit_cfg) |=> base == $past(bus_wdata[15:4]));
  assert_mmask_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && hit_mst) |=> mmask == $past(bus_wdata[9:6]));
  assert_status_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && hit_win && !wsel_mask) |=> $stable(smask));
endmodule

// File: tb/slot_irq_agg_tb.sv
`timescale 1ns/1ps
module slot_irq_agg_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  bridge_cfg = '0;
  logic [63:0] irq_lines = '0;
  logic [15:0] bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        irq_out;
  logic [7:0]  irq_vec;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  slot_irq_agg u_dut (
    .clk(clk), .rst_n(rst_n), .bridge_cfg(bridge_cfg), .irq_lines(irq_lines),
    .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_out(irq_out), .irq_vec(irq_vec)
  );

  typedef struct packed {
    logic [3:0]  br;
    logic [63:0] ln;
    logic [15:0] mw;
    logic        ex_irq;
    logic [7:0]  ex_vec;
    logic [15:0] ex_m;
  } row_t;

  localparam row_t TBL [9] = '{
    '{4'h0, 64'h0,                   16'h4000, 1'b0, 8'h00, 16'h4000},
    '{4'h0, 64'h1,                   16'h4000, 1'b1, 8'h11, 16'h4001},
    '{4'h0, 64'h0000_0000_0040_0000, 16'h4000, 1'b0, 8'h00, 16'h4000},
    '{4'h2, 64'h0000_0000_0040_0000, 16'h4000, 1'b1, 8'h27, 16'h4002},
    '{4'h0, 64'h0008_0002_0000_0000, 16'h4000, 1'b1, 8'h32, 16'h400C},
    '{4'h0, 64'h0008_0002_0000_0000, 16'h0000, 1'b0, 8'h00, 16'h000C},
    '{4'h0, 64'h0008_0002_0000_0000, 16'h4100, 1'b1, 8'h44, 16'h4108},
    '{4'hF, 64'h8000_0000_0000_0000, 16'h4000, 1'b1, 8'h50, 16'h4008},
    '{4'h3, 64'h0000_0000_0010_0000, 16'hFC00, 1'b1, 8'h25, 16'hFC02}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [15:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    bridge_cfg = 4'h3;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(16'h0500, d); chk("R1 master", d, 16'h0000);
    rd(16'h0502, d); chk("R1 config", d, 16'h0513);
    rd(16'h0512, d); chk("R1 mask1", d, 16'h0000);
    chk("R1 irq", irq_out, 0);
    chk("R1 vec", irq_vec, 0);

    // table walk: R3 R6 R7 R8
    foreach (TBL[i]) begin
      @(negedge clk);
      bridge_cfg = TBL[i].br;
      irq_lines  = TBL[i].ln;
      wr(16'h0500, TBL[i].mw);
      repeat (2) @(negedge clk);
      chk($sformatf("R7 row%0d irq", i), irq_out, TBL[i].ex_irq);
      chk($sformatf("R8 row%0d vec", i), irq_vec, TBL[i].ex_vec);
      rd(16'h0500, d);
      chk($sformatf("R6 row%0d master", i), d, TBL[i].ex_m);
    end

    // R3 synchroniser latency
    wr(16'h0500, 16'h4000);
    bridge_cfg = 4'h1;
    irq_lines = '0;
    repeat (3) @(negedge clk);
    irq_lines = 64'h21;
    @(negedge clk);
    chk("R3 one edge", irq_out, 0);
    @(negedge clk);
    chk("R3 two edges", irq_out, 1);
    rd(16'h0510, d); chk("R3 status1", d, 16'h0021);

    // R5 per-slot masks
    wr(16'h0500, 16'h6000);
    wr(16'h0512, 16'h0001);
    chk("R5 vec after mask", irq_vec, 8'h16);
    rd(16'h0510, d); chk("R5 raw status", d, 16'h0021);
    wr(16'h0512, 16'h0021);
    chk("R5 all masked irq", irq_out, 0);
    rd(16'h0500, d); chk("R5 master", d, 16'h6000);
    wr(16'h0500, 16'h4000);
    chk("R5 mask-enable off", irq_vec, 8'h11);
    wr(16'h0516, 16'hFFFF);
    rd(16'h0516, d); chk("R5 plain slot mask", d, 16'h000F);

    // R4 status writes ignored
    wr(16'h0510, 16'hFFFF);
    rd(16'h0510, d); chk("R4 status", d, 16'h0021);
    rd(16'h0512, d); chk("R4 mask kept", d, 16'h0021);
    chk("R4 vec", irq_vec, 8'h11);

    // R2 relocation and read-only bridge field
    wr(16'h0502, 16'h0A0F);
    rd(16'h0502, d); chk("R2 config", d, 16'h0A01);
    rd(16'h0A00, d); chk("R2 new window", d, 16'h0021);
    rd(16'h0A02, d); chk("R2 new mask", d, 16'h0021);

    // R9 unmapped reads
    rd(16'h0510, d); chk("R9 old window", d, 16'h0000);
    rd(16'h05F0, d); chk("R9 unmapped", d, 16'h0000);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule